// File: doc/BRIEF.md
# SMBus Indexed Block Register Target

This block is a serial-bus target that lets a host read and write a small eight-entry configuration and identification register file. Every access is an indexed block transfer. A write carries a starting index, a byte count and then the data bytes. A read first sets the index with a write. It then issues a repeated start with the read bit set. The target answers with a byte count, followed by consecutive register bytes.

Both bus lines are oversampled by the system clock through two-flop synchronizers. Start and stop are found as SDA edges while SCL is high. The target drives SDA only as an open-drain pull-low enable. The 7-bit address variant and a 2-bit spread setting are captured from strap pins on the first clock at which `pwr_good` is high after reset. The bus is ignored until that capture has happened.

The control states are:
- `ST_IDLE`: no transfer in progress.
- `ST_ADDR`, `ST_INDEX`, `ST_COUNT`, `ST_WDATA`: receiving the address byte, the index byte, the count byte or a data byte.
- `ST_ADDR_ACK`, `ST_INDEX_ACK`, `ST_COUNT_ACK`, `ST_WDATA_ACK`: the target pulls SDA low for the acknowledge bit.
- `ST_TX`: the target shifts a byte out.
- `ST_TX_ACK`: the target samples the host's acknowledge.
- `ST_IGNORE`: the target stays off the bus until the next start or stop.

Transitions are counted on SCL falling edges:
- A start moves any state to `ST_ADDR`, and a stop moves any state to `ST_IDLE`.
- A full address byte goes to `ST_ADDR_ACK` on a match, otherwise to `ST_IGNORE`.
- Each acknowledge state leads to the next byte state of the write sequence.
- A read address goes from `ST_ADDR_ACK` to `ST_TX`.
- `ST_COUNT_ACK` and `ST_WDATA_ACK` go to `ST_IGNORE` once the remaining write count is zero.
- `ST_TX_ACK` returns to `ST_TX` on a host acknowledge and goes to `ST_IGNORE` on a not-acknowledge.

Top module: `smb_blkreg_target`

## Requirements
- R1: The target acknowledges address 0x68 if `addr_strap` was 0, and 0x6A if it was 1, at the first clock with `pwr_good` high after reset. Before that capture, no address is acknowledged. Later changes on the strap pins have no effect.
- R2: A write (start, address with bit0 = 0, index N, count X, X data bytes, stop) has every byte acknowledged. The data bytes are stored into registers N, N+1, and so on.
- R3: Data bytes beyond the count X are not acknowledged and are not stored. A count of 0 stores nothing.
- R4: After a repeated start with the read address (bit0 = 1), the first byte returned is {3'b000, register 7 bits 4:0}. It is followed by registers N, N+1, ... for as long as the host acknowledges. A host not-acknowledge makes the target release SDA.
- R5: After reset:
  - `oe_mask` and `slew_sel` are 0xFF and `amp_sel` is 2'b10.
  - The read count in register 7 is 8.
  - `sda_drive_low` is 0.
- R6: Register 1 reads {spread[1:0], 4'b0000, amp[1:0]}:
  - The spread field is 00, 01 or 11 for a captured `spread_strap` of 0, 1 or 2/3.
  - Bits 1:0 are writable and drive `amp_sel`.
  - Bits 5:2 read 0, and writes to bits 7:2 are ignored.
- R7: Register 5 reads 0x11, register 6 reads 0x08, and registers 3 and 4 read 0x00. Writes to these four are acknowledged and change nothing.
- R8: Indices 8 to 255 read 0x00. Writes to them are acknowledged and discarded.
- R9: `sda_drive_low` changes only while the synchronized SCL is low. A stop returns the target to idle with SDA released. A start at any point restarts the address phase.
- R10: A byte on the bus with a non-matching address is not acknowledged, and the rest of that transfer is ignored.
- R11: Register 0 drives `oe_mask` and register 2 drives `slew_sel`, bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Power-good; its first high level after reset captures the straps |
| addr_strap | input | 1 | Address variant strap: 0 selects 0x68, 1 selects 0x6A |
| spread_strap | input | 2 | Spread strap level: 0 off, 1 middle, 2 or 3 high |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad (wired value) |
| sda_drive_low | output | 1 | Pull-low enable for the SDA open-drain pad |
| oe_mask | output | 8 | Output-enable bits held in register 0 |
| slew_sel | output | 8 | Slew-select bits held in register 2 |
| amp_sel | output | 2 | Amplitude code from register 1 bits 1:0 (00=0.55V, 01=0.65V, 10=0.7V, 11=0.8V) |

## Verification
SCL and SDA each pass through two synchronizer flops and one edge register. A bus event therefore reaches the control logic two clocks after it appears on a pin, and `sda_drive_low` and any register write settle on the third clock. The host model changes SDA a quarter SCL period after each falling edge and samples SDA one system clock before SCL falls. Every acknowledge and read bit is therefore checked long after its three-cycle due point and before the target may move it again. Register outputs are compared only after the stop condition, when every write has landed.

// File: rtl/smb_blk_pkg.sv
package smb_blk_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INDEX,
        ST_INDEX_ACK,
        ST_COUNT,
        ST_COUNT_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } bus_state_e;

    localparam logic [6:0] TGT_ADDR_LO = 7'b1101000;
    localparam logic [6:0] TGT_ADDR_HI = 7'b1101010;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_seen,
    output logic stop_seen
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe[0] <= scl_in;
            sda_pipe[0] <= sda_in;
            for (int i = 1; i < STAGES; i++) begin
                scl_pipe[i] <= scl_pipe[i-1];
                sda_pipe[i] <= sda_pipe[i-1];
            end
            scl_d <= scl_pipe[STAGES-1];
            sda_d <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s      = scl_pipe[STAGES-1];
    assign sda_s      = sda_pipe[STAGES-1];
    assign scl_rise   = scl_s & ~scl_d;
    assign scl_fall   = ~scl_s & scl_d;
    assign start_seen = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_seen  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/smb_cfg_regs.sv
module smb_cfg_regs #(
    parameter int              NUM_REGS  = 8,
    parameter int              IDX_W     = 8,
    parameter int              DATA_W    = 8,
    parameter int              CNT_W     = 5,
    parameter int              CNT_RESET = 8,
    parameter int              AMP_W     = 2,
    parameter int              AMP_RESET = 2,
    parameter logic [7:0]      REV_ID    = 8'h11,
    parameter logic [7:0]      DEV_ID    = 8'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [1:0]        spread_rb,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] oe_mask,
    output logic [DATA_W-1:0] slew_sel,
    output logic [AMP_W-1:0]  amp_sel,
    output logic [CNT_W-1:0]  byte_count
);

    localparam int MISC_PAD = DATA_W - 2 - AMP_W;
    localparam logic [IDX_W-1:0] IDX_OE   = IDX_W'(0);
    localparam logic [IDX_W-1:0] IDX_MISC = IDX_W'(1);
    localparam logic [IDX_W-1:0] IDX_SLEW = IDX_W'(2);
    localparam logic [IDX_W-1:0] IDX_REV  = IDX_W'(5);
    localparam logic [IDX_W-1:0] IDX_DEV  = IDX_W'(6);
    localparam logic [IDX_W-1:0] IDX_CNT  = IDX_W'(7);

    logic [DATA_W-1:0] oe_q;
    logic [DATA_W-1:0] slew_q;
    logic [AMP_W-1:0]  amp_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q   <= '1;
            slew_q <= '1;
            amp_q  <= AMP_W'(AMP_RESET);
            cnt_q  <= CNT_W'(CNT_RESET);
        end else if (wr_en) begin
            case (wr_idx)
                IDX_OE:   oe_q   <= wr_data;
                IDX_MISC: amp_q  <= wr_data[AMP_W-1:0];
                IDX_SLEW: slew_q <= wr_data;
                IDX_CNT:  cnt_q  <= wr_data[CNT_W-1:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (rd_idx)
            IDX_OE:   rd_data = oe_q;
            IDX_MISC: rd_data = {spread_rb, {MISC_PAD{1'b0}}, amp_q};
            IDX_SLEW: rd_data = slew_q;
            IDX_REV:  rd_data = REV_ID;
            IDX_DEV:  rd_data = DEV_ID;
            IDX_CNT:  rd_data = {{(DATA_W-CNT_W){1'b0}}, cnt_q};
            default:  rd_data = '0;
        endcase
    end

    assign oe_mask    = oe_q;
    assign slew_sel   = slew_q;
    assign amp_sel    = amp_q;
    assign byte_count = cnt_q;

    AST_OOR_WRITE_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx >= IDX_W'(NUM_REGS)) |=> ($stable(oe_mask) && $stable(slew_sel) && $stable(amp_sel) && $stable(byte_count))) // R8
        else $error("out-of-range write changed state");

    AST_RO_WRITE_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx >= IDX_W'(3) && wr_idx <= IDX_W'(6)) |=> ($stable(oe_mask) && $stable(slew_sel) && $stable(amp_sel) && $stable(byte_count))) // R7
        else $error("read-only write changed state");

endmodule

// File: rtl/smb_proto_fsm.sv
module smb_proto_fsm
    import smb_blk_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed,
    input  logic [6:0]       own_addr,
    input  logic             scl_s,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_seen,
    input  logic             stop_seen,
    input  logic [7:0]       rd_data,
    input  logic [CNT_W-1:0] byte_count,
    output logic             wr_en,
    output logic [7:0]       wr_idx,
    output logic [7:0]       wr_data,
    output logic [7:0]       rd_idx,
    output logic             sda_drive_low
);

    bus_state_e st, st_nx;
    logic [3:0] bit_cnt;
    logic [7:0] shreg;
    logic [7:0] txsh;
    logic [7:0] ptr;
    logic [7:0] wr_left;
    logic       rd_mode;
    logic       host_nack;
    logic       drive;
    logic       byte_done;
    logic       addr_hit;
    logic       rx_state;
    logic [7:0] count_byte;

    assign byte_done  = (bit_cnt == 4'd8);
    assign addr_hit   = (shreg[7:1] == own_addr);
    assign rx_state   = (st == ST_ADDR) || (st == ST_INDEX) || (st == ST_COUNT) || (st == ST_WDATA);
    assign count_byte = {{(8-CNT_W){1'b0}}, byte_count};

    // next-state selection
    always_comb begin
        st_nx = st;
        if (!armed) begin
            st_nx = ST_IDLE;
        end else if (start_seen) begin
            st_nx = ST_ADDR;
        end else if (stop_seen) begin
            st_nx = ST_IDLE;
        end else if (scl_fall) begin
            unique case (st)
                ST_IDLE, ST_IGNORE: st_nx = st;
                ST_ADDR:      if (byte_done) st_nx = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  st_nx = rd_mode ? ST_TX : ST_INDEX;
                ST_INDEX:     if (byte_done) st_nx = ST_INDEX_ACK;
                ST_INDEX_ACK: st_nx = ST_COUNT;
                ST_COUNT:     if (byte_done) st_nx = ST_COUNT_ACK;
                ST_COUNT_ACK: st_nx = (wr_left == 8'd0) ? ST_IGNORE : ST_WDATA;
                ST_WDATA:     if (byte_done) st_nx = ST_WDATA_ACK;
                ST_WDATA_ACK: st_nx = (wr_left == 8'd0) ? ST_IGNORE : ST_WDATA;
                ST_TX:        if (byte_done) st_nx = ST_TX_ACK;
                ST_TX_ACK:    st_nx = host_nack ? ST_IGNORE : ST_TX;
                default:      st_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            txsh      <= '0;
            ptr       <= '0;
            wr_left   <= '0;
            rd_mode   <= 1'b0;
            host_nack <= 1'b0;
            drive     <= 1'b0;
            wr_en     <= 1'b0;
            wr_idx    <= '0;
            wr_data   <= '0;
        end else begin
            wr_en <= 1'b0;
            if (!armed || start_seen || stop_seen) begin
                drive   <= 1'b0;
                bit_cnt <= '0;
            end else begin
                if (scl_rise) begin
                    if (rx_state) begin
                        shreg   <= {shreg[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                    if (st == ST_TX)     bit_cnt   <= bit_cnt + 4'd1;
                    if (st == ST_TX_ACK) host_nack <= sda_s;
                end
                if (scl_fall) begin
                    unique case (st)
                        ST_ADDR: if (byte_done) begin
                            rd_mode <= shreg[0];
                            drive   <= addr_hit;
                        end
                        ST_INDEX: if (byte_done) begin
                            ptr   <= shreg;
                            drive <= 1'b1;
                        end
                        ST_COUNT: if (byte_done) begin
                            wr_left <= shreg;
                            drive   <= 1'b1;
                        end
                        ST_WDATA: if (byte_done) begin
                            wr_en   <= 1'b1;
                            wr_idx  <= ptr;
                            wr_data <= shreg;
                            ptr     <= ptr + 8'd1;
                            wr_left <= wr_left - 8'd1;
                            drive   <= 1'b1;
                        end
                        ST_ADDR_ACK: begin
                            bit_cnt <= '0;
                            if (rd_mode) begin
                                txsh  <= count_byte;
                                drive <= ~count_byte[7];
                            end else begin
                                drive <= 1'b0;
                            end
                        end
                        ST_INDEX_ACK, ST_COUNT_ACK, ST_WDATA_ACK: begin
                            bit_cnt <= '0;
                            drive   <= 1'b0;
                        end
                        ST_TX: begin
                            if (byte_done) begin
                                drive <= 1'b0;
                            end else begin
                                txsh  <= {txsh[6:0], 1'b0};
                                drive <= ~txsh[6];
                            end
                        end
                        ST_TX_ACK: begin
                            bit_cnt <= '0;
                            if (!host_nack) begin
                                txsh  <= rd_data;
                                drive <= ~rd_data[7];
                                ptr   <= ptr + 8'd1;
                            end else begin
                                drive <= 1'b0;
                            end
                        end
                        ST_IDLE, ST_IGNORE: ;
                        default: ;
                    endcase
                end
            end
        end
    end

    assign rd_idx        = ptr;
    assign sda_drive_low = drive;

    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_drive_low) |-> !scl_s) // R9
        else $error("SDA drive changed with SCL high");

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sda_drive_low) // R9
        else $error("SDA held in idle");

    AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && start_seen) |=> (st == ST_ADDR && bit_cnt == 4'd0)) // R9
        else $error("start did not restart address phase");

    AST_WRITE_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !scl_s) // R2
        else $error("register write outside SCL low");

    AST_NO_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IGNORE && $past(st) == ST_IGNORE) |-> !sda_drive_low) // R10
        else $error("driving while ignoring bus");

endmodule

// File: rtl/smb_blkreg_target.sv
module smb_blkreg_target
    import smb_blk_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int NUM_REGS    = 8,
    parameter int CNT_W       = 5,
    parameter int AMP_W       = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_good,
    input  logic             addr_strap,
    input  logic [1:0]       spread_strap,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             sda_drive_low,
    output logic [7:0]       oe_mask,
    output logic [7:0]       slew_sel,
    output logic [AMP_W-1:0] amp_sel
);

    logic       strap_done;
    logic       addr_alt;
    logic [1:0] spread_rb;
    logic [6:0] own_addr;

    logic scl_s, sda_s, scl_rise, scl_fall, start_seen, stop_seen;
    logic             wr_en;
    logic [7:0]       wr_idx, wr_data, rd_idx, rd_data;
    logic [CNT_W-1:0] byte_count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strap_done <= 1'b0;
            addr_alt   <= 1'b0;
            spread_rb  <= 2'b00;
        end else if (!strap_done && pwr_good) begin
            strap_done <= 1'b1;
            addr_alt   <= addr_strap;
            unique case (spread_strap)
                2'd0:    spread_rb <= 2'b00;
                2'd1:    spread_rb <= 2'b01;
                default: spread_rb <= 2'b11;
            endcase
        end
    end

    assign own_addr = addr_alt ? TGT_ADDR_HI : TGT_ADDR_LO;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (scl_in),
        .sda_in     (sda_in),
        .scl_s      (scl_s),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_seen (start_seen),
        .stop_seen  (stop_seen)
    );

    smb_proto_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .armed         (strap_done),
        .own_addr      (own_addr),
        .scl_s         (scl_s),
        .sda_s         (sda_s),
        .scl_rise      (scl_rise),
        .scl_fall      (scl_fall),
        .start_seen    (start_seen),
        .stop_seen     (stop_seen),
        .rd_data       (rd_data),
        .byte_count    (byte_count),
        .wr_en         (wr_en),
        .wr_idx        (wr_idx),
        .wr_data       (wr_data),
        .rd_idx        (rd_idx),
        .sda_drive_low (sda_drive_low)
    );

    smb_cfg_regs #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (8),
        .DATA_W   (8),
        .CNT_W    (CNT_W),
        .AMP_W    (AMP_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .rd_idx     (rd_idx),
        .spread_rb  (spread_rb),
        .rd_data    (rd_data),
        .oe_mask    (oe_mask),
        .slew_sel   (slew_sel),
        .amp_sel    (amp_sel),
        .byte_count (byte_count)
    );

    AST_QUIET_BEFORE_STRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !strap_done |-> !sda_drive_low) // R1
        else $error("bus driven before strap capture");

    AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        strap_done |=> (strap_done && $stable(own_addr) && $stable(spread_rb))) // R1
        else $error("strap value moved after capture");

endmodule

// File: tb/test_smb_blkreg_target.sv
module test_smb_blkreg_target;

    localparam int HALF = 20;
    localparam int QTR  = 10;
    localparam int NVEC = 9;
    localparam logic [6:0] A_LO = 7'h68;
    localparam logic [6:0] A_HI = 7'h6A;

    // {index, write byte, expected readback}
    localparam logic [23:0] VEC [NVEC] = '{
        {8'd0, 8'h5A, 8'h5A},
        {8'd2, 8'h3C, 8'h3C},
        {8'd1, 8'hFF, 8'h43},
        {8'd5, 8'h00, 8'h11},
        {8'd6, 8'hFF, 8'h08},
        {8'd4, 8'hAB, 8'h00},
        {8'd3, 8'h77, 8'h00},
        {8'd9, 8'h55, 8'h00},
        {8'd7, 8'hE3, 8'h03}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good = 1'b0;
    logic addr_strap = 1'b0;
    logic [1:0] spread_strap = 2'd0;
    logic scl_h = 1'b1;
    logic sda_h = 1'b1;
    logic sda_bus;
    logic sda_drive_low;
    logic [7:0] oe_mask, slew_sel;
    logic [1:0] amp_sel;
    int total = 0;
    int bad = 0;

    assign sda_bus = sda_h & ~sda_drive_low;
    always #4 clk = ~clk;

    smb_blkreg_target i_smb_blkreg_target (
        .clk           (clk),
        .rst_n         (rst_n),
        .pwr_good      (pwr_good),
        .addr_strap    (addr_strap),
        .spread_strap  (spread_strap),
        .scl_in        (scl_h),
        .sda_in        (sda_bus),
        .sda_drive_low (sda_drive_low),
        .oe_mask       (oe_mask),
        .slew_sel      (slew_sel),
        .amp_sel       (amp_sel)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_h = 1'b0; wait_n(HALF);
        scl_h = 1'b0; wait_n(QTR);
    endtask

    task automatic bus_rstart();
        sda_h = 1'b1; wait_n(QTR);
        scl_h = 1'b1; wait_n(HALF);
        sda_h = 1'b0; wait_n(HALF);
        scl_h = 1'b0; wait_n(QTR);
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; wait_n(QTR);
        scl_h = 1'b1; wait_n(HALF);
        sda_h = 1'b1; wait_n(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_h = b[i]; wait_n(QTR);
            scl_h = 1'b1; wait_n(HALF);
            scl_h = 1'b0; wait_n(QTR);
        end
        sda_h = 1'b1; wait_n(QTR);
        scl_h = 1'b1; wait_n(HALF - 1);
        acked = (sda_bus == 1'b0);
        wait_n(1);
        scl_h = 1'b0; wait_n(QTR);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_h = 1'b1;
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            wait_n(QTR);
            scl_h = 1'b1; wait_n(HALF - 1);
            b = {b[6:0], sda_bus};
            wait_n(1);
            scl_h = 1'b0; wait_n(QTR);
        end
        sda_h = ~give_ack; wait_n(QTR);
        scl_h = 1'b1; wait_n(HALF);
        scl_h = 1'b0; wait_n(QTR);
        sda_h = 1'b1;
    endtask

    // write: addr, index, count, nd data bytes; ack bit per byte sent
    task automatic wr_txn(input logic [6:0] a, input logic [7:0] idx, input logic [7:0] cnt,
                          input int nd, input logic [31:0] d, output logic [7:0] am);
        logic k;
        am = 8'h00;
        bus_start();
        send_byte({a, 1'b0}, k); am[0] = k;
        send_byte(idx, k);       am[1] = k;
        send_byte(cnt, k);       am[2] = k;
        for (int i = 0; i < nd; i++) begin
            send_byte(d[8*i +: 8], k); am[3+i] = k;
        end
        bus_stop();
    endtask

    // read: set index, repeated start, read count byte then n bytes
    task automatic rd_txn(input logic [6:0] a, input logic [7:0] idx, input int n,
                          output logic [7:0] cnt, output logic [31:0] r, output logic aa);
        logic k;
        logic [7:0] b;
        r = 32'h0;
        bus_start();
        send_byte({a, 1'b0}, k);
        send_byte(idx, k);
        bus_rstart();
        send_byte({a, 1'b1}, aa);
        recv_byte(n != 0, cnt);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            r[8*i +: 8] = b;
        end
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] am;
        logic [7:0] cnt;
        logic [31:0] rd;
        logic aa;
        logic k;
        int exp_cnt;

        // reset defaults
        wait_n(5);
        check("R5", "reset sda_drive_low", {31'd0, sda_drive_low}, 32'd0);
        check("R5", "reset oe_mask", {24'd0, oe_mask}, 32'hFF);
        check("R5", "reset slew_sel", {24'd0, slew_sel}, 32'hFF);
        check("R5", "reset amp_sel", {30'd0, amp_sel}, 32'd2);
        rst_n = 1'b1;
        wait_n(5);

        // before strap capture nothing is acknowledged
        wr_txn(A_LO, 8'd0, 8'd1, 1, 32'h00, am);
        check("R1", "ack before power-good", {24'd0, am}, 32'h00);
        check("R1", "oe untouched before power-good", {24'd0, oe_mask}, 32'hFF);

        addr_strap = 1'b1;
        spread_strap = 2'd1;
        pwr_good = 1'b1;
        wait_n(5);
        addr_strap = 1'b0;
        spread_strap = 2'd2;
        wait_n(5);

        // other address ignored
        wr_txn(A_LO, 8'd0, 8'd1, 1, 32'h00, am);
        check("R10", "other address acks", {24'd0, am}, 32'h00);
        check("R10", "oe after foreign write", {24'd0, oe_mask}, 32'hFF);

        // vector table: single-byte write then read back
        exp_cnt = 8;
        for (int v = 0; v < NVEC; v++) begin
            wr_txn(A_HI, VEC[v][23:16], 8'd1, 1, {24'd0, VEC[v][15:8]}, am);
            check("R2", $sformatf("vec %0d write acks", v), {24'd0, am}, 32'h0F);
            if (VEC[v][23:16] == 8'd7) exp_cnt = VEC[v][15:8] & 8'h1F;
            rd_txn(A_HI, VEC[v][23:16], 1, cnt, rd, aa);
            check("R4", $sformatf("vec %0d read addr ack", v), {31'd0, aa}, 32'd1);
            check("R4", $sformatf("vec %0d count byte", v), {24'd0, cnt}, exp_cnt);
            check("R6 R7 R8", $sformatf("vec %0d data idx %0d", v, VEC[v][23:16]), rd[7:0], {24'd0, VEC[v][7:0]});
        end
        check("R11", "oe_mask after table", {24'd0, oe_mask}, 32'h5A);
        check("R11", "slew_sel after table", {24'd0, slew_sel}, 32'h3C);
        check("R6", "amp_sel after table", {30'd0, amp_sel}, 32'd3);

        // multi-byte write and block read
        wr_txn(A_HI, 8'd0, 8'd3, 3, 32'h00332211, am);
        check("R2", "block write acks", {24'd0, am}, 32'h3F);
        rd_txn(A_HI, 8'd0, 3, cnt, rd, aa);
        check("R4", "block read count", {24'd0, cnt}, 32'd3);
        check("R4", "block read bytes", rd, 32'h00334211);
        check("R6", "amp after block write", {30'd0, amp_sel}, 32'd2);
        check("R9", "released after read", {31'd0, sda_drive_low}, 32'd0);

        // bytes past count
        wr_txn(A_HI, 8'd0, 8'd1, 2, 32'h00006577, am);
        check("R3", "extra byte nacked", {24'd0, am}, 32'h0F);
        check("R3", "counted byte stored", {24'd0, oe_mask}, 32'h77);
        check("R3", "extra byte not stored", {30'd0, amp_sel}, 32'd2);

        // zero count
        wr_txn(A_HI, 8'd2, 8'd0, 1, 32'h00000001, am);
        check("R3", "zero count acks", {24'd0, am}, 32'h07);
        check("R3", "zero count no store", {24'd0, slew_sel}, 32'h33);

        // sequential read across the end of the file
        rd_txn(A_HI, 8'd6, 3, cnt, rd, aa);
        check("R8", "read past end", rd, 32'h00000308);

        // stop in the middle, then a restarted write
        bus_start();
        send_byte({A_HI, 1'b0}, k);
        send_byte(8'd2, k);
        bus_stop();
        check("R9", "idle after early stop", {31'd0, sda_drive_low}, 32'd0);
        bus_start();
        send_byte({A_HI, 1'b0}, k);
        send_byte(8'd0, k);
        send_byte(8'd1, k);
        bus_rstart();
        send_byte({A_HI, 1'b0}, k);
        check("R9", "address after repeated start", {31'd0, k}, 32'd1);
        send_byte(8'd2, k);
        send_byte(8'd1, k);
        send_byte(8'h5C, k);
        bus_stop();
        check("R9", "slew after restarted write", {24'd0, slew_sel}, 32'h5C);
        check("R9", "oe kept after restart", {24'd0, oe_mask}, 32'h77);

        // second power-up with the other strap settings
        rst_n = 1'b0;
        pwr_good = 1'b0;
        addr_strap = 1'b0;
        spread_strap = 2'd2;
        wait_n(5);
        rst_n = 1'b1;
        wait_n(3);
        pwr_good = 1'b1;
        wait_n(5);
        wr_txn(A_HI, 8'd0, 8'd1, 1, 32'h00, am);
        check("R1", "old address after re-strap", {24'd0, am}, 32'h00);
        rd_txn(A_LO, 8'd1, 1, cnt, rd, aa);
        check("R1", "low address acked", {31'd0, aa}, 32'd1);
        check("R5", "default count", {24'd0, cnt}, 32'd8);
        check("R6", "spread high readback", rd, 32'h000000C2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule